// File: doc/BRIEF.md
# Interrupt Command Write Qualifier

This block sits on the guest register-write path of a virtualized interrupt controller. It watches every guest write and picks out the ones aimed at the interrupt command register. Such a write can arrive in two forms. One is a memory-mapped page write at a fixed page offset. The other is a model-specific register write at a fixed register index. For each such write the block checks the enable controls and the fields of the command word.

A write that passes every check takes the no-exit fast path. Its data is mirrored into the virtual register page, and a send request goes to the destination resolver. A write that fails any check is flagged so that the pipeline traps to the hypervisor in the conventional way. Writes to any other address are not this block's concern and produce nothing.

The block takes one write per cycle. All of its outputs are registered and appear one cycle after the write. Destination lookup and the actual interrupt signalling belong to other blocks.

Top module: `icr_write_qualifier`

## Requirements
- R1: While rst_ni is low, and after reset until the first write, all outputs are 0.
- R2: A write qualifies only if it targets the command register: page form (wr_kind_i=0) with wr_addr_i[11:0]=0x300, or register form (wr_kind_i=1) with wr_addr_i=0x830. Any other write, or a cycle with wr_valid_i=0, leaves every output 0 in the following cycle.
- R3: The fast path requires both virt_intr_en_i=1 and safe_ipi_en_i=1. The register form additionally requires x2_virt_en_i=1, while the page form ignores x2_virt_en_i. A targeted write without its enables traps.
- R4: The reserved bits of the low command word must be zero. These are bits 31:20, 17:16 and 13 in both forms. Bit 12 must also be zero in both forms: in the page form it is the delivery-status bit, in the register form it is reserved.
- R5: A targeted write traps if the shorthand field (bits 19:18) is not 00, if the trigger bit 15 is 1, or if the delivery-mode field (bits 10:8) is not 000.
- R6: A targeted write traps if vector bits 7:4 are 0000. The vectors 0x10 and above are accepted.
- R7: Destination-mode bit 11 (0 physical, 1 logical) and bit 14 have no effect on qualification.
- R8: A qualified write yields, one cycle later, a one-cycle send_valid_o. With it, send_vector_o is data[7:0], send_logical_o is data[11] and send_dest_o is data[63:32], in both forms. These fields are 0 when send_valid_o is 0.
- R9: A qualified write pulses mirror_we_o in the same cycle as send_valid_o, with mirror_data_o equal to the full 64-bit write data. In the register form, mirror_ofs_o is (index & 0xFF) << 4, which gives 0x300, and mirror_strb_o is 2'b11. In the page form, mirror_ofs_o is the page offset and mirror_strb_o is 2'b01, meaning only the low word is written. The offset and data are 0 when mirror_we_o is 0.
- R10: A targeted write that fails any check pulses trap_o for one cycle and raises neither mirror_we_o nor send_valid_o.
- R11: Back-to-back writes each get their own result in consecutive cycles, and every output pulse lasts exactly one cycle per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | A guest write is present this cycle |
| wr_kind_i | input | 1 | 0 page form, 1 register form |
| wr_addr_i | input | 32 | Page offset in bits 11:0 (page form) or register index (register form) |
| wr_data_i | input | 64 | Write data; the low word is the command, the upper word is the destination |
| virt_intr_en_i | input | 1 | Virtual interrupt delivery enable |
| safe_ipi_en_i | input | 1 | Safe interrupt issue enable |
| x2_virt_en_i | input | 1 | Register-form virtualization enable |
| send_valid_o | output | 1 | Send request to the destination resolver |
| send_vector_o | output | 8 | Requested vector |
| send_logical_o | output | 1 | Destination mode, 1 means logical |
| send_dest_o | output | 32 | Destination field |
| mirror_we_o | output | 1 | Virtual page write enable |
| mirror_ofs_o | output | 12 | Virtual page offset |
| mirror_data_o | output | 64 | Virtual page write data |
| mirror_strb_o | output | 2 | Word enables; bit 0 is the low word, bit 1 the high word |
| trap_o | output | 1 | Trap the write to the hypervisor |

## Verification
The bench builds the block with its default parameters. These are a 12-bit page offset, offset 0x300, index 0x830, and an 8-bit index select shifted left by 4. With these values the index-to-offset mapping lands on exactly the page offset the page form uses, so both forms can be compared on the same mirror address. The 32-bit index lets the bench try indices such as 0x1830 and 0x831, which share most bits with the target but must not match. Random command words, each a clean qualified word with one flipped bit, visit every reserved, shorthand, trigger, mode and vector bit position under both forms. Directed cases pin the vector boundary at 0x0F and 0x10 and each enable on its own.

// File: rtl/icr_qual_pkg.sv
package icr_qual_pkg;
  typedef enum logic {
    ACC_PAGE = 1'b0,
    ACC_REG  = 1'b1
  } acc_kind_e;

  // command word field positions
  localparam int unsigned VEC_LSB     = 0;
  localparam int unsigned VEC_HI_LSB  = 4;
  localparam int unsigned VEC_W       = 8;
  localparam int unsigned DMODE_LSB   = 8;
  localparam int unsigned DMODE_W     = 3;
  localparam int unsigned LOGICAL_BIT = 11;
  localparam int unsigned STATUS_BIT  = 12;
  localparam int unsigned TRIG_BIT    = 15;
  localparam int unsigned SHORT_LSB   = 18;
  localparam int unsigned SHORT_W     = 2;

  typedef struct packed {
    logic                    hit;
    logic                    pass;
    logic                    kind;
    logic [VEC_W-1:0]        vector;
    logic                    logical;
  } qual_res_t;
endpackage

// File: rtl/icr_addr_match.sv
module icr_addr_match #(
  parameter int unsigned              PAGE_W    = 12,
  parameter int unsigned              IDX_W     = 32,
  parameter int unsigned              IDX_SEL_W = 8,
  parameter int unsigned              IDX_SHIFT = 4,
  parameter logic [PAGE_W-1:0]        PAGE_OFS  = 12'h300,
  parameter logic [IDX_W-1:0]         REG_IDX   = 32'h830
) (
  input  logic              kind_i,
  input  logic [IDX_W-1:0]  addr_i,
  output logic              hit_o,
  output logic [PAGE_W-1:0] ofs_o
);
  import icr_qual_pkg::*;

  localparam int unsigned RAW_W = IDX_SEL_W + IDX_SHIFT;

  logic              page_hit;
  logic              reg_hit;
  logic [RAW_W-1:0]  reg_ofs_raw;
  logic [PAGE_W-1:0] reg_ofs;

  assign page_hit    = (addr_i[PAGE_W-1:0] == PAGE_OFS);
  assign reg_hit     = (addr_i == REG_IDX);
  assign reg_ofs_raw = {addr_i[IDX_SEL_W-1:0], {IDX_SHIFT{1'b0}}};

  generate
    if (RAW_W >= PAGE_W) begin : g_trunc
      assign reg_ofs = reg_ofs_raw[PAGE_W-1:0];
    end else begin : g_pad
      assign reg_ofs = {{(PAGE_W-RAW_W){1'b0}}, reg_ofs_raw};
    end
  endgenerate

  always_comb begin
    if (kind_i == ACC_REG) begin
      hit_o = reg_hit;
      ofs_o = reg_ofs;
    end else begin
      hit_o = page_hit;
      ofs_o = addr_i[PAGE_W-1:0];
    end
  end
endmodule

// File: rtl/icr_field_check.sv
module icr_field_check #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              kind_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              fmt_ok_o
);
  import icr_qual_pkg::*;

  localparam logic [WORD_W-1:0] RSV_COMMON = (~(WORD_W'(0)) << 20) | WORD_W'(32'h0003_2000);
  localparam logic [WORD_W-1:0] BIT12      = WORD_W'(1) << STATUS_BIT;
  localparam logic [WORD_W-1:0] SHORT_MASK = WORD_W'((1 << SHORT_W) - 1) << SHORT_LSB;
  localparam logic [WORD_W-1:0] TRIG_MASK  = WORD_W'(1) << TRIG_BIT;
  localparam logic [WORD_W-1:0] DMODE_MASK = WORD_W'((1 << DMODE_W) - 1) << DMODE_LSB;

  logic rsv_page_ok;
  logic rsv_reg_ok;
  logic status_clear;
  logic rsv_ok;
  logic short_ok;
  logic trig_ok;
  logic dmode_ok;
  logic vec_ok;

  // page form: bit 12 is delivery status, must read as idle
  assign status_clear = ((word_i & BIT12) == '0);
  assign rsv_page_ok  = ((word_i & RSV_COMMON) == '0) && status_clear;
  // register form: bit 12 is plainly reserved
  assign rsv_reg_ok   = ((word_i & (RSV_COMMON | BIT12)) == '0);

  assign rsv_ok   = (kind_i == ACC_REG) ? rsv_reg_ok : rsv_page_ok;
  assign short_ok = ((word_i & SHORT_MASK) == '0);
  assign trig_ok  = ((word_i & TRIG_MASK) == '0);
  assign dmode_ok = ((word_i & DMODE_MASK) == '0);
  assign vec_ok   = (word_i[VEC_W-1:VEC_HI_LSB] != '0);

  assign fmt_ok_o = rsv_ok && short_ok && trig_ok && dmode_ok && vec_ok;
endmodule

// File: rtl/icr_enable_gate.sv
module icr_enable_gate (
  input  logic kind_i,
  input  logic virt_intr_en_i,
  input  logic safe_ipi_en_i,
  input  logic x2_virt_en_i,
  output logic en_ok_o
);
  import icr_qual_pkg::*;

  logic base_ok;

  assign base_ok = virt_intr_en_i && safe_ipi_en_i;
  assign en_ok_o = (kind_i == ACC_REG) ? (base_ok && x2_virt_en_i) : base_ok;
endmodule

// File: rtl/icr_out_stage.sv
module icr_out_stage #(
  parameter int unsigned PAGE_W = 12,
  parameter int unsigned WORD_W = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  icr_qual_pkg::qual_res_t res_i,
  input  logic [PAGE_W-1:0]     ofs_i,
  input  logic [2*WORD_W-1:0]   data_i,
  output logic                  send_valid_o,
  output logic [7:0]            send_vector_o,
  output logic                  send_logical_o,
  output logic [WORD_W-1:0]     send_dest_o,
  output logic                  mirror_we_o,
  output logic [PAGE_W-1:0]     mirror_ofs_o,
  output logic [2*WORD_W-1:0]   mirror_data_o,
  output logic [1:0]            mirror_strb_o,
  output logic                  trap_o
);
  import icr_qual_pkg::*;

  logic go;
  logic fail;

  assign go   = res_i.hit && res_i.pass;
  assign fail = res_i.hit && !res_i.pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_valid_o   <= 1'b0;
      send_vector_o  <= '0;
      send_logical_o <= 1'b0;
      send_dest_o    <= '0;
      mirror_we_o    <= 1'b0;
      mirror_ofs_o   <= '0;
      mirror_data_o  <= '0;
      mirror_strb_o  <= '0;
      trap_o         <= 1'b0;
    end else begin
      send_valid_o   <= go;
      send_vector_o  <= go ? res_i.vector : '0;
      send_logical_o <= go && res_i.logical;
      send_dest_o    <= go ? data_i[2*WORD_W-1:WORD_W] : '0;
      mirror_we_o    <= go;
      mirror_ofs_o   <= go ? ofs_i : '0;
      mirror_data_o  <= go ? data_i : '0;
      mirror_strb_o  <= !go ? 2'b00 : ((res_i.kind == ACC_REG) ? 2'b11 : 2'b01);
      trap_o         <= fail;
    end
  end

  assert_trap_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> !(send_valid_o || mirror_we_o));
  assert_strb_kind_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_we_o |-> (mirror_strb_o[0] && $onehot0(mirror_strb_o ^ 2'b01) ));
endmodule

// File: rtl/icr_write_qualifier.sv
module icr_write_qualifier #(
  parameter int unsigned       PAGE_W    = 12,
  parameter int unsigned       IDX_W     = 32,
  parameter int unsigned       WORD_W    = 32,
  parameter int unsigned       IDX_SEL_W = 8,
  parameter int unsigned       IDX_SHIFT = 4,
  parameter logic [PAGE_W-1:0] PAGE_OFS  = 12'h300,
  parameter logic [IDX_W-1:0]  REG_IDX   = 32'h830
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_valid_i,
  input  logic                wr_kind_i,
  input  logic [IDX_W-1:0]    wr_addr_i,
  input  logic [2*WORD_W-1:0] wr_data_i,
  input  logic                virt_intr_en_i,
  input  logic                safe_ipi_en_i,
  input  logic                x2_virt_en_i,
  output logic                send_valid_o,
  output logic [7:0]          send_vector_o,
  output logic                send_logical_o,
  output logic [WORD_W-1:0]   send_dest_o,
  output logic                mirror_we_o,
  output logic [PAGE_W-1:0]   mirror_ofs_o,
  output logic [2*WORD_W-1:0] mirror_data_o,
  output logic [1:0]          mirror_strb_o,
  output logic                trap_o
);
  import icr_qual_pkg::*;

  logic              addr_hit;
  logic [PAGE_W-1:0] page_ofs;
  logic              fmt_ok;
  logic              en_ok;
  qual_res_t         res;

  icr_addr_match #(
    .PAGE_W(PAGE_W), .IDX_W(IDX_W), .IDX_SEL_W(IDX_SEL_W),
    .IDX_SHIFT(IDX_SHIFT), .PAGE_OFS(PAGE_OFS), .REG_IDX(REG_IDX)
  ) u_match (
    .kind_i (wr_kind_i),
    .addr_i (wr_addr_i),
    .hit_o  (addr_hit),
    .ofs_o  (page_ofs)
  );

  icr_field_check #(.WORD_W(WORD_W)) u_fields (
    .kind_i   (wr_kind_i),
    .word_i   (wr_data_i[WORD_W-1:0]),
    .fmt_ok_o (fmt_ok)
  );

  icr_enable_gate u_gate (
    .kind_i         (wr_kind_i),
    .virt_intr_en_i (virt_intr_en_i),
    .safe_ipi_en_i  (safe_ipi_en_i),
    .x2_virt_en_i   (x2_virt_en_i),
    .en_ok_o        (en_ok)
  );

  always_comb begin
    res.hit     = wr_valid_i && addr_hit;
    res.pass    = fmt_ok && en_ok;
    res.kind    = wr_kind_i;
    res.vector  = wr_data_i[VEC_W-1:0];
    res.logical = wr_data_i[LOGICAL_BIT];
  end

  icr_out_stage #(.PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_out (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .res_i          (res),
    .ofs_i          (page_ofs),
    .data_i         (wr_data_i),
    .send_valid_o   (send_valid_o),
    .send_vector_o  (send_vector_o),
    .send_logical_o (send_logical_o),
    .send_dest_o    (send_dest_o),
    .mirror_we_o    (mirror_we_o),
    .mirror_ofs_o   (mirror_ofs_o),
    .mirror_data_o  (mirror_data_o),
    .mirror_strb_o  (mirror_strb_o),
    .trap_o         (trap_o)
  );

  assert_send_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_o || trap_o) |-> $past(wr_valid_i));
  assert_send_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_valid_o |-> $past(virt_intr_en_i && safe_ipi_en_i));
  assert_reg_needs_x2_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (send_valid_o && $past(wr_kind_i)) |-> $past(x2_virt_en_i));
  assert_vector_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_valid_o |-> (send_vector_o[7:4] != 4'h0));
  assert_mirror_pairs_send_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mirror_we_o |-> (send_valid_o && send_dest_o == mirror_data_o[2*WORD_W-1:WORD_W]));
  assert_data_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    send_valid_o |-> (send_vector_o == $past(wr_data_i[7:0])));
endmodule

// File: tb/sim_icr_write_qualifier.sv
module sim_icr_write_qualifier;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic        wr_kind_i = 1'b0;
  logic [31:0] wr_addr_i = '0;
  logic [63:0] wr_data_i = '0;
  logic        virt_intr_en_i = 1'b0;
  logic        safe_ipi_en_i = 1'b0;
  logic        x2_virt_en_i = 1'b0;
  logic        send_valid_o;
  logic [7:0]  send_vector_o;
  logic        send_logical_o;
  logic [31:0] send_dest_o;
  logic        mirror_we_o;
  logic [11:0] mirror_ofs_o;
  logic [63:0] mirror_data_o;
  logic [1:0]  mirror_strb_o;
  logic        trap_o;

  always #2.5 clk_i = ~clk_i;

  icr_write_qualifier u0 (.*);

  typedef struct packed {
    logic        send;
    logic [7:0]  vec;
    logic        logical;
    logic [31:0] dest;
    logic        we;
    logic [11:0] ofs;
    logic [63:0] data;
    logic [1:0]  strb;
    logic        trap;
  } exp_t;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  exp_t        exp_q = '0;
  string       tag_q = "R1";
  bit          done = 1'b0;

  function automatic exp_t model(bit v, bit k, logic [31:0] a, logic [63:0] d,
                                 bit ev, bit es, bit ex);
    exp_t e = '0;
    logic [31:0] lo = d[31:0];
    bit hit, en, fmt;
    hit = k ? (a == 32'h830) : (a[11:0] == 12'h300);
    if (!v || !hit) return e;
    en  = ev && es && (k ? ex : 1'b1);
    fmt = ((lo & 32'hFFF3_3000) == 0) && (lo[19:18] == 2'b00) && !lo[15]
          && (lo[10:8] == 3'b000) && (lo[7:4] != 4'h0);
    if (en && fmt) begin
      e.send = 1; e.vec = lo[7:0]; e.logical = lo[11]; e.dest = d[63:32];
      e.we = 1; e.data = d; e.strb = k ? 2'b11 : 2'b01;
      e.ofs = k ? {a[7:0], 4'h0} : a[11:0];
    end else e.trap = 1;
    return e;
  endfunction

  function automatic exp_t actual();
    return {send_valid_o, send_vector_o, send_logical_o, send_dest_o, mirror_we_o,
            mirror_ofs_o, mirror_data_o, mirror_strb_o, trap_o};
  endfunction

  task automatic check_now();
    exp_t act = actual();
    n_chk++;
    if (act !== exp_q) begin
      n_bad++;
      $display("FAIL %s: act %h exp %h", tag_q, act, exp_q);
    end
  endtask

  // drive at negedge, check one negedge later (one register stage)
  task automatic step(bit v, bit k, logic [31:0] a, logic [63:0] d,
                      bit ev, bit es, bit ex, string tag);
    wr_valid_i = v; wr_kind_i = k; wr_addr_i = a; wr_data_i = d;
    virt_intr_en_i = ev; safe_ipi_en_i = es; x2_virt_en_i = ex;
    exp_q = model(v, k, a, d, ev, es, ex);
    tag_q = tag;
    @(negedge clk_i);
    check_now();
  endtask

  task automatic wr(bit k, logic [31:0] lo, string tag);
    step(1, k, k ? 32'h830 : 32'h300, {32'hA5C3_0F11, lo}, 1, 1, 1, tag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: act hung exp done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'h1CE5_7A11));
    repeat (3) @(negedge clk_i);
    exp_q = '0; tag_q = "R1 in reset";
    check_now();
    rst_ni = 1'b1;
    @(negedge clk_i);
    tag_q = "R1 after reset";
    check_now();

    // directed corners
    wr(0, 32'h0000_0030, "R8 page basic");
    wr(1, 32'h0000_0830, "R8 reg logical");
    step(0, 0, 32'h300, 64'h1, 1, 1, 1, "R11 idle after pass");
    wr(0, 32'h0000_000F, "R6 vec 0x0F page");
    wr(1, 32'h0000_0010, "R6 vec 0x10 reg");
    wr(1, 32'h0000_00FF, "R6 vec 0xFF reg");
    wr(0, 32'h0000_1040, "R4 page status bit");
    wr(1, 32'h0000_1040, "R4 reg bit12");
    wr(0, 32'h0000_2040, "R4 bit13");
    wr(1, 32'h0001_0040, "R4 bit16");
    wr(0, 32'h8000_0040, "R4 bit31");
    wr(0, 32'h0000_4840, "R7 bit14 and logical");
    wr(1, 32'h0004_0040, "R5 shorthand");
    wr(0, 32'h0000_8040, "R5 trigger");
    wr(1, 32'h0000_0140, "R5 delivery mode");
    step(1, 0, 32'h0000_0310, 64'h40, 1, 1, 1, "R2 page 0x310");
    step(1, 1, 32'h0000_0831, 64'h40, 1, 1, 1, "R2 reg 0x831");
    step(1, 1, 32'h0000_1830, 64'h40, 1, 1, 1, "R2 reg 0x1830");
    step(1, 0, 32'hFFFF_F300, 64'h40, 1, 1, 1, "R2 page upper addr bits");
    step(1, 1, 32'h830, 64'h40, 0, 1, 1, "R3 virt off");
    step(1, 0, 32'h300, 64'h40, 1, 0, 1, "R3 safe off");
    step(1, 1, 32'h830, 64'h40, 1, 1, 0, "R3 reg x2 off");
    step(1, 0, 32'h300, 64'h40, 1, 1, 0, "R3 page x2 ignored");
    step(0, 1, 32'h830, 64'h40, 1, 1, 1, "R11 idle");
    wr(0, 32'h0000_0051, "R9 page mirror");
    wr(1, 32'h0000_0052, "R9 reg mirror");
    wr(0, 32'h0000_0500, "R10 fail then");
    wr(0, 32'h0000_0060, "R11 back-to-back pass");

    // constrained random
    for (int i = 0; i < 3000; i++) begin
      bit k = $urandom_range(0, 1) == 1;
      logic [31:0] a, lo;
      logic [63:0] d;
      int r = $urandom_range(0, 9);
      a = (r < 8) ? (k ? 32'h830 : {$urandom_range(0, 15) == 0 ? $urandom : 32'h0, 12'h300} & (k ? 32'hFFFF_FFFF : 32'hFFFF_FFFF))
                  : $urandom;
      if (!k && r < 8) a = {$urandom() & 32'hFFFFF, 12'h300} ;
      lo = {16'h0, 1'b0, 1'($urandom_range(0, 1)), 2'b00, 1'($urandom_range(0, 1)), 3'b000,
            4'($urandom_range(1, 15)), 4'($urandom)};
      if ($urandom_range(0, 2) == 0) lo[$urandom_range(0, 31)] ^= 1'b1;
      d = {$urandom, lo};
      step($urandom_range(0, 7) != 0, k, a, d, $urandom_range(0, 7) != 0,
           $urandom_range(0, 7) != 0, $urandom_range(0, 7) != 0, "R4-random R8 R9 R10");
    end
    step(0, 0, 32'h0, 64'h0, 0, 0, 0, "R11 final idle");

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule